// File: doc/BRIEF.md
# USB Receive Overrun and Oversize Handler

This block owns the data stage of one endpoint while a packet is received. A packet engine hands it payload bytes one at a time, framed by a start pulse and an end pulse. The block latches a buffer descriptor at the start of the packet: a base address, the largest payload the buffer may take, and the token PID. It then queues each byte in a small FIFO and writes it to memory at base plus byte index through a simple write port that has a ready signal.

Two faults are caught. The first is a latency overrun: the FIFO is full, memory will not take a word, and another byte arrives. The second is an oversized packet, where more bytes arrive than the buffer may hold. When the packet ends, the block chooses the handshake to return, writes the byte count and PID back to the descriptor, pulses a completion interrupt and sets a sticky DMA-error flag. The flag raises an interrupt line only when its enable is set. The descriptor PID value tells the two faults apart: it keeps the token PID after an oversize and becomes all ones after a latency overrun.

Top module: `usb_rx_ovf_handler`

## Requirements
- R1: Each stored byte is written once to address base + index, where index counts received bytes from 0, and bytes keep their order.
- R2: On a non-isochronous packet longer than the limit, only the first limit bytes are written, no write falls outside [base, base+limit), and the handshake is still ACK (hs_nak = 0). A packet exactly as long as the limit is not oversized.
- R3: After an oversized packet the write-back count equals the limit, the write-back PID equals the latched token PID, done_irq pulses once and err_flag is set.
- R4: An isochronous endpoint never gets a handshake (hs_valid stays 0). An oversized isochronous packet is still clipped, written back and flagged.
- R5: A latency overrun occurs only when a byte that would be stored arrives while the FIFO holds 8 unwritten bytes and mem_wr_ready is 0. A byte that arrives at a full FIFO while mem_wr_ready is 1 is stored normally. After an overrun, no further memory writes are issued for that packet.
- R6: In host mode a latency overrun gives no handshake, and a write-back with PID 4'hF and count equal to the bytes already written. It also pulses done_irq once and sets err_flag.
- R7: In device mode a non-isochronous latency overrun answers NAK (hs_nak = 1). It gives no write-back and no done_irq, and it sets err_flag.
- R8: A packet of in-range length with no overrun on a non-isochronous endpoint returns ACK (hs_nak = 0). It writes back the byte count and the token PID, pulses done_irq once and leaves err_flag clear.
- R9: err_flag is write-one-to-clear through err_clr and stays set until cleared. If a new error and a clear fall on the same edge, the flag ends set.
- R10: err_irq is high exactly when err_flag is set and err_irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = block acts as host, 0 = device |
| iso_ep | input | 1 | Endpoint is isochronous |
| desc_base | input | ADDR_W | Descriptor buffer base address |
| desc_maxpkt | input | CNT_W | Descriptor maximum packet size |
| token_pid | input | 4 | PID of the token that opened the transaction |
| pkt_start | input | 1 | Packet begins; descriptor fields are latched |
| byte_valid | input | 1 | A payload byte is present |
| byte_data | input | 8 | Payload byte |
| pkt_end | input | 1 | Packet has ended |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_wr_ready | input | 1 | Memory accepts the write this cycle |
| hs_valid | output | 1 | Handshake to be sent (one-cycle pulse) |
| hs_nak | output | 1 | Handshake kind: 0 = ACK, 1 = NAK |
| wb_valid | output | 1 | Descriptor write-back strobe |
| wb_count | output | CNT_W | Byte count written back |
| wb_pid | output | 4 | PID field written back |
| done_irq | output | 1 | Transfer-complete interrupt pulse |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_irq_en | input | 1 | Error interrupt enable |
| err_flag | output | 1 | Sticky DMA-error status bit |
| err_irq | output | 1 | Error interrupt line |

## Verification
Two events collide inside the FIFO. A byte can arrive at a full FIFO in the same cycle as memory takes or refuses a word, and only the refusing case is an overrun. The bench holds ready low while eight bytes fill the FIFO. It then raises ready exactly as the ninth byte arrives and expects a clean packet; the same stimulus with ready held low must give the overrun outcome. A second collision lands a software clear on the completion cycle of an oversized packet, and the bench expects the flag to survive.

// File: rtl/usb_rxo_pkg.sv
package usb_rxo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } rxo_state_e;

  localparam logic [3:0] PID_LATENCY_FAIL = 4'hF;
endpackage

// File: rtl/rxo_fifo.sv
module rxo_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign rd_data = store[rp];

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push) wp_n = (wp == LAST_IDX) ? '0 : wp + PW'(1);
      if (pop)  rp_n = (rp == LAST_IDX) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   cnt_n = cnt + CW'(1);
        2'b01:   cnt_n = cnt - CW'(1);
        default: cnt_n = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= push_data;
  end

  // R5: the controller must never push into a full queue unless a word leaves
  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);

  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxo_err_reg.sv
module rxo_err_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_n;

  always_comb begin
    flag_n = flag;
    if (clr) flag_n = 1'b0;
    if (set) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_n;
  end

  assign irq = flag && irq_en;

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
  import usb_rxo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [CNT_W-1:0]  desc_maxpkt,
  input  logic [3:0]        token_pid,
  input  logic              iso_ep,
  input  logic              host_mode,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              mem_pop,
  output logic              push,
  output logic [ADDR_W+7:0] push_data,
  output logic              flush,
  output logic              wr_enable,
  output logic              hs_valid,
  output logic              hs_nak,
  output logic              wb_valid,
  output logic [CNT_W-1:0]  wb_count,
  output logic [3:0]        wb_pid,
  output logic              err_set,
  output logic [ADDR_W-1:0] win_base,
  output logic [CNT_W-1:0]  win_len
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  rxo_state_e        state, state_n;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  max_q;
  logic [3:0]        pid_q;
  logic              iso_q, host_q;
  logic [CNT_W-1:0]  rx_cnt, rx_cnt_n;
  logic [CNT_W-1:0]  mem_cnt, mem_cnt_n;
  logic              ovf_q, ovf_n;
  logic              lat_q, lat_n;
  logic              cap_en;
  logic              in_range, take_byte, accept, lat_hit, ovf_hit;

  assign cap_en    = (state == ST_IDLE) && pkt_start;
  assign take_byte = (state == ST_RECV) && byte_valid && !lat_q;
  assign in_range  = (rx_cnt < max_q);
  assign accept    = take_byte && in_range;
  assign lat_hit   = accept && fifo_full && !mem_pop;
  assign ovf_hit   = take_byte && !in_range;
  assign push      = accept && !lat_hit;
  assign push_data = {base_q + ADDR_W'(rx_cnt), byte_data};
  assign flush     = (state == ST_DRAIN) && lat_q;
  assign wr_enable = !lat_q;

  always_comb begin
    state_n   = state;
    rx_cnt_n  = rx_cnt;
    mem_cnt_n = mem_cnt;
    ovf_n     = ovf_q;
    lat_n     = lat_q;
    if (mem_pop) mem_cnt_n = mem_cnt + CNT_ONE;
    case (state)
      ST_IDLE: begin
        if (pkt_start) begin
          state_n   = ST_RECV;
          rx_cnt_n  = '0;
          mem_cnt_n = '0;
          ovf_n     = 1'b0;
          lat_n     = 1'b0;
        end
      end
      ST_RECV: begin
        if (lat_hit) lat_n = 1'b1;
        if (ovf_hit) ovf_n = 1'b1;
        if (push)    rx_cnt_n = rx_cnt + CNT_ONE;
        if (pkt_end) state_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (lat_q || fifo_empty) state_n = ST_DONE;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx_cnt  <= '0;
      mem_cnt <= '0;
      ovf_q   <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      state   <= state_n;
      rx_cnt  <= rx_cnt_n;
      mem_cnt <= mem_cnt_n;
      ovf_q   <= ovf_n;
      lat_q   <= lat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      max_q  <= '0;
      pid_q  <= '0;
      iso_q  <= 1'b0;
      host_q <= 1'b0;
    end else if (cap_en) begin
      base_q <= desc_base;
      max_q  <= desc_maxpkt;
      pid_q  <= token_pid;
      iso_q  <= iso_ep;
      host_q <= host_mode;
    end
  end

  logic at_done;
  assign at_done  = (state == ST_DONE);
  assign hs_valid = at_done && !iso_q && !(lat_q && host_q);
  assign hs_nak   = at_done && lat_q;
  assign wb_valid = at_done && !(lat_q && !host_q);
  assign wb_count = mem_cnt;
  assign wb_pid   = lat_q ? PID_LATENCY_FAIL : pid_q;
  assign err_set  = at_done && (lat_q || ovf_q);
  assign win_base = base_q;
  assign win_len  = max_q;

  a_r4_iso_no_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> !iso_q);

  a_r6_latency_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && lat_q) |-> (wb_pid == PID_LATENCY_FAIL));

  a_r7_nak_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_nak) |-> !wb_valid);

  a_r3_count_clipped: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_count <= max_q));

  a_r5_no_write_after_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q |-> !mem_pop);
endmodule

// File: rtl/usb_rx_ovf_handler.sv
module usb_rx_ovf_handler #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 11,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              iso_ep,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [CNT_W-1:0]  desc_maxpkt,
  input  logic [3:0]        token_pid,
  input  logic              pkt_start,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              pkt_end,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  input  logic              mem_wr_ready,
  output logic              hs_valid,
  output logic              hs_nak,
  output logic              wb_valid,
  output logic [CNT_W-1:0]  wb_count,
  output logic [3:0]        wb_pid,
  output logic              done_irq,
  input  logic              err_clr,
  input  logic              err_irq_en,
  output logic              err_flag,
  output logic              err_irq
);
  localparam int FW = ADDR_W + 8;

  logic rst_meta_n, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic              push, flush, wr_enable, fifo_empty, fifo_full, mem_pop, err_set;
  logic [FW-1:0]     push_data, rd_data;
  logic [ADDR_W-1:0] win_base;
  logic [CNT_W-1:0]  win_len;

  rxo_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .push_data (push_data),
    .pop       (mem_pop),
    .flush     (flush),
    .rd_data   (rd_data),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  rxo_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .pkt_start   (pkt_start),
    .pkt_end     (pkt_end),
    .byte_valid  (byte_valid),
    .byte_data   (byte_data),
    .desc_base   (desc_base),
    .desc_maxpkt (desc_maxpkt),
    .token_pid   (token_pid),
    .iso_ep      (iso_ep),
    .host_mode   (host_mode),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .mem_pop     (mem_pop),
    .push        (push),
    .push_data   (push_data),
    .flush       (flush),
    .wr_enable   (wr_enable),
    .hs_valid    (hs_valid),
    .hs_nak      (hs_nak),
    .wb_valid    (wb_valid),
    .wb_count    (wb_count),
    .wb_pid      (wb_pid),
    .err_set     (err_set),
    .win_base    (win_base),
    .win_len     (win_len)
  );

  rxo_err_reg u_err (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .set    (err_set),
    .clr    (err_clr),
    .irq_en (err_irq_en),
    .flag   (err_flag),
    .irq    (err_irq)
  );

  assign mem_wr_valid = !fifo_empty && wr_enable;
  assign mem_pop      = mem_wr_valid && mem_wr_ready;
  assign mem_wr_addr  = rd_data[FW-1:8];
  assign mem_wr_data  = rd_data[7:0];
  assign done_irq     = wb_valid;

  // R2: every write lands inside the buffer window of the current descriptor
  a_r2_write_in_window: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_wr_valid |-> ((mem_wr_addr - win_base) < ADDR_W'(win_len)));

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_core_n)
    done_irq |=> !done_irq);
endmodule

// File: tb/usb_rx_ovf_handler_tb.sv
module usb_rx_ovf_handler_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 11;

  logic              clk, rst_n;
  logic              host_mode, iso_ep;
  logic [ADDR_W-1:0] desc_base;
  logic [CNT_W-1:0]  desc_maxpkt;
  logic [3:0]        token_pid;
  logic              pkt_start, byte_valid, pkt_end;
  logic [7:0]        byte_data;
  logic              mem_wr_valid, mem_wr_ready;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [7:0]        mem_wr_data;
  logic              hs_valid, hs_nak, wb_valid, done_irq;
  logic [CNT_W-1:0]  wb_count;
  logic [3:0]        wb_pid;
  logic              err_clr, err_irq_en, err_flag, err_irq;

  usb_rx_ovf_handler #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FIFO_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .iso_ep(iso_ep),
    .desc_base(desc_base), .desc_maxpkt(desc_maxpkt), .token_pid(token_pid),
    .pkt_start(pkt_start), .byte_valid(byte_valid), .byte_data(byte_data),
    .pkt_end(pkt_end), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .hs_valid(hs_valid),
    .hs_nak(hs_nak), .wb_valid(wb_valid), .wb_count(wb_count), .wb_pid(wb_pid),
    .done_irq(done_irq), .err_clr(err_clr), .err_irq_en(err_irq_en),
    .err_flag(err_flag), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  logic [7:0] pkt [0:127];
  logic [7:0] img [0:127];
  bit         img_set [0:127];
  int n_wr, n_oob, n_hs, n_nak, n_wb, n_done, occ, sent, ready_mode;
  logic [CNT_W-1:0] last_count;
  logic [3:0]       last_pid;
  logic [ADDR_W-1:0] cur_base;
  int cur_max;
  bit clr_on_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  task automatic step(input bit sv, input bit bv, input logic [7:0] bd,
                      input bit ev, input bit will_store, input bit clr);
    bit rdy;
    logic [ADDR_W-1:0] off;
    @(negedge clk);
    if (hs_valid) begin n_hs++; if (hs_nak) n_nak++; end
    if (wb_valid) begin n_wb++; last_count = wb_count; last_pid = wb_pid; end
    if (done_irq) n_done++;
    pkt_start  = sv;
    byte_valid = bv;
    byte_data  = bd;
    pkt_end    = ev;
    err_clr    = clr | (clr_on_done & done_irq);
    case (ready_mode)
      1:       rdy = (($urandom % 3) != 0) || (occ >= 6);
      2:       rdy = 1'b0;
      3:       rdy = (sent >= 8);
      default: rdy = 1'b1;
    endcase
    mem_wr_ready = rdy;
    if (mem_wr_valid && rdy) begin
      off = mem_wr_addr - cur_base;
      if (int'(off) < cur_max) begin
        img[off[6:0]] = mem_wr_data;
        img_set[off[6:0]] = 1;
      end else n_oob++;
      n_wr++;
      occ--;
    end
    if (will_store) occ++;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic clear_flag();
    step(0, 0, 8'h00, 0, 0, 1);
    step(0, 0, 8'h00, 0, 0, 0);
  endtask

  // rmode: 0 ready high, 1 random ready, 2 ready low, 3 ready low for 8 bytes
  task automatic run_pkt(input int len, input int maxp, input bit iso, input bit host,
                         input int rmode, input bit lat, input bit gaps);
    int i, stored, exp_wr, bad;
    bit bv, exp_hs, exp_wb;
    logic [3:0] pid;
    pid = 4'($urandom);
    cur_base = ADDR_W'($urandom);
    cur_max = maxp;
    for (int k = 0; k < len; k++) pkt[k] = 8'($urandom);
    for (int k = 0; k < 128; k++) img_set[k] = 0;
    n_wr = 0; n_oob = 0; n_hs = 0; n_nak = 0; n_wb = 0; n_done = 0;
    occ = 0; sent = 0; ready_mode = rmode;
    host_mode = host; iso_ep = iso; desc_base = cur_base;
    desc_maxpkt = CNT_W'(maxp); token_pid = pid;
    step(1, 0, 8'h00, 0, 0, 0);
    i = 0;
    while (i < len) begin
      bv = gaps ? (($urandom % 10) < 7) : 1'b1;
      step(0, bv, bv ? pkt[i] : 8'h00, 0, bv && (i < maxp), 0);
      if (bv) begin i++; sent++; end
    end
    step(0, 0, 8'h00, 1, 0, 0);
    ready_mode = 0;
    idle(25);
    stored = (len < maxp) ? len : maxp;
    exp_wr = lat ? 0 : stored;
    chk(n_oob == 0, "R2", "writes outside buffer", n_oob, 0);
    chk(n_wr == exp_wr, "R1", "memory write count", n_wr, exp_wr);
    bad = 0;
    for (int k = 0; k < exp_wr; k++)
      if (!img_set[k] || img[k] !== pkt[k]) bad++;
    chk(bad == 0, "R1", "bytes stored wrong", bad, 0);
    exp_hs = !iso && !(lat && host);
    chk(n_hs == int'(exp_hs), iso ? "R4" : (lat ? "R6" : "R8"), "handshake count",
        n_hs, int'(exp_hs));
    if (exp_hs)
      chk(n_nak == int'(lat), lat ? "R7" : "R2", "NAK count", n_nak, int'(lat));
    exp_wb = !(lat && !host);
    chk(n_wb == int'(exp_wb), lat ? "R7" : "R8", "write-back count", n_wb, int'(exp_wb));
    chk(n_done == int'(exp_wb), lat ? "R6" : "R3", "done pulses", n_done, int'(exp_wb));
    if (exp_wb && n_wb == 1) begin
      chk(int'(last_count) == exp_wr, lat ? "R6" : "R3", "written-back count",
          int'(last_count), exp_wr);
      chk(last_pid == (lat ? 4'hF : pid), lat ? "R6" : "R3", "written-back PID",
          int'(last_pid), lat ? 15 : int'(pid));
    end
    chk(err_flag == (lat || (len > maxp)), len > maxp ? "R3" : "R9", "error flag",
        int'(err_flag), int'(lat || (len > maxp)));
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    rst_n = 0; host_mode = 0; iso_ep = 0; desc_base = '0; desc_maxpkt = '0;
    token_pid = '0; pkt_start = 0; byte_valid = 0; byte_data = '0; pkt_end = 0;
    mem_wr_ready = 1; err_clr = 0; err_irq_en = 1; ready_mode = 0; cur_max = 0;
    cur_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle(4);
    chk(!mem_wr_valid && !hs_valid && !wb_valid && !done_irq, "R8", "reset outputs quiet",
        int'({mem_wr_valid, hs_valid, wb_valid, done_irq}), 0);
    chk(!err_flag && !err_irq, "R9", "reset error flag", int'(err_flag), 0);

    // R8 plain packet, R2 exact-limit boundary, R2/R3 one byte over
    run_pkt(10, 16, 0, 0, 0, 0, 0);
    run_pkt(16, 16, 0, 1, 0, 0, 0);
    run_pkt(17, 16, 0, 0, 0, 0, 0);
    clear_flag();
    // R4 oversized isochronous
    run_pkt(20, 8, 1, 0, 0, 0, 0);
    clear_flag();
    // R5/R6 host latency overrun, R5/R7 device latency overrun
    run_pkt(12, 64, 0, 1, 2, 1, 0);
    clear_flag();
    run_pkt(12, 64, 0, 0, 2, 1, 0);
    clear_flag();
    // R5 full FIFO but memory ready on the same cycle: no overrun
    run_pkt(12, 64, 0, 0, 3, 0, 0);
    // R9 clear on the completion cycle of an oversized packet: set wins
    clr_on_done = 1;
    run_pkt(30, 20, 0, 1, 0, 0, 0);
    clr_on_done = 0;
    chk(err_flag == 1'b1, "R9", "flag after set and clear collide", int'(err_flag), 1);
    // R10 enable gating
    @(negedge clk) err_irq_en = 0;
    #1 chk(err_irq == 1'b0, "R10", "irq masked", int'(err_irq), 0);
    @(negedge clk) err_irq_en = 1;
    #1 chk(err_irq == 1'b1, "R10", "irq enabled", int'(err_irq), 1);
    clear_flag();
    chk(err_flag == 1'b0 && err_irq == 1'b0, "R9", "flag cleared by write-one",
        int'(err_flag), 0);

    for (int n = 0; n < 40; n++) begin
      run_pkt(1 + int'($urandom % 80), 1 + int'($urandom % 64), 1'($urandom),
              1'($urandom), 1, 0, 1);
      clear_flag();
    end
    summary();
  end
endmodule